// File: doc/BRIEF.md
# Live Insertion Transaction Gate

This block stands between a bridge's stored command-register bits and the logic that accepts transactions. It produces the I/O-space, memory-space and bus-master enables that the bridge actually uses. When a live-insertion mode is armed and a chosen general-purpose input is high, all three enables drop to zero. The stored bits are never changed, so register readback still returns what configuration software wrote.

While the gate is closed, new I/O and memory traffic is refused as a target on both interfaces. Work that is already queued as master, meaning posted writes and delayed requests, may still drain. Delayed completions are held back from the requester. Configuration traffic is not affected. A status output shows when the gate is closed and the queues are empty, so software can then assert the active-low secondary bus reset through its control bit.

Top module: `hotswap_txn_gate`

## Requirements
- R1: While `rst_n` is low, `sec_rst_n` is 0 and the pin synchroniser is cleared. After reset, `gated` is 0 and each effective enable equals its stored command bit.
- R2: The gate can only close when `hs_mode` is 1 and `gp_dir_out` is 0 (pin set as input). With `hs_mode` at 0, a high pin has no effect on any output.
- R3: While `gated` is 1, `eff_io_en`, `eff_mem_en`, `eff_mst_en`, `tgt_io_ok` and `tgt_mem_ok` are all 0. The target qualifiers apply to both the primary and secondary interfaces.
- R4: While `gated` is 0, each effective enable equals its stored command bit in the same cycle, including the cycle in which the gate reopens.
- R5: `gp_pin` passes through two flip-flops. A level change on the pin shows on `gated` only after the second rising clock edge that follows it.
- R6: `drain_ok` equals `cmd_mst_en` whether or not the gate is closed, so queued posted writes and delayed requests can still complete.
- R7: `cpl_ret_ok` is 0 while `gated` is 1 and 1 otherwise, so delayed completions are held back while the gate is closed.
- R8: With `gp_dir_out` at 1 (pin set as output), `gated` stays 0 whatever `hs_mode` and `gp_pin` hold.
- R9: `sec_rst_n` is the inverse of `sec_rst_ctl`, registered. It changes on the first rising edge after the control bit changes.
- R10: `safe_pt` is 1 exactly when `gated` is 1 and `q_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_io_en | input | 1 | Stored I/O-space enable bit |
| cmd_mem_en | input | 1 | Stored memory-space enable bit |
| cmd_mst_en | input | 1 | Stored bus-master enable bit |
| hs_mode | input | 1 | Live-insertion mode control bit |
| gp_dir_out | input | 1 | 1 = designated pin is set as an output |
| gp_pin | input | 1 | Designated pin level (asynchronous) |
| q_empty | input | 1 | All transaction queues are empty |
| sec_rst_ctl | input | 1 | Secondary-reset control bit |
| eff_io_en | output | 1 | Effective I/O enable |
| eff_mem_en | output | 1 | Effective memory enable |
| eff_mst_en | output | 1 | Effective master enable for new requests |
| tgt_io_ok | output | 1 | New I/O target transactions may be accepted |
| tgt_mem_ok | output | 1 | New memory target transactions may be accepted |
| drain_ok | output | 1 | Queued master work may complete |
| cpl_ret_ok | output | 1 | Delayed completions may be returned |
| gated | output | 1 | Live-insertion gate is closed |
| safe_pt | output | 1 | Gate is closed and the queues are empty |
| sec_rst_n | output | 1 | Active-low secondary bus reset |

## Verification
Two events can land in the same cycle: the synchronised pin falling, which reopens the gate, and software writing new command bits. The bench changes the command bits on the exact clock edge at which the second synchroniser stage drops. It then checks that the effective enables show the new stored values, not the old ones and not zero. A second overlap is the queue-empty flag rising in the cycle the gate closes. Here `safe_pt` must rise together with `gated`.

// File: rtl/hotswap_txn_gate.sv
module hotswap_txn_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_io_en,
  input  logic cmd_mem_en,
  input  logic cmd_mst_en,
  input  logic hs_mode,
  input  logic gp_dir_out,
  input  logic gp_pin,
  input  logic q_empty,
  input  logic sec_rst_ctl,
  output logic eff_io_en,
  output logic eff_mem_en,
  output logic eff_mst_en,
  output logic tgt_io_ok,
  output logic tgt_mem_ok,
  output logic drain_ok,
  output logic cpl_ret_ok,
  output logic gated,
  output logic safe_pt,
  output logic sec_rst_n
);

  logic pin_m, pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_m     <= 1'b0;
      pin_s     <= 1'b0;
      sec_rst_n <= 1'b0;
    end else begin
      pin_m     <= gp_pin;
      pin_s     <= pin_m;
      sec_rst_n <= ~sec_rst_ctl;
    end
  end

  assign gated      = hs_mode & ~gp_dir_out & pin_s;
  assign eff_io_en  = cmd_io_en  & ~gated;
  assign eff_mem_en = cmd_mem_en & ~gated;
  assign eff_mst_en = cmd_mst_en & ~gated;
  assign tgt_io_ok  = eff_io_en;
  assign tgt_mem_ok = eff_mem_en;
  assign drain_ok   = cmd_mst_en;
  assign cpl_ret_ok = ~gated;
  assign safe_pt    = gated & q_empty;

  assert_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gated |-> (!eff_io_en && !eff_mem_en && !eff_mst_en && !tgt_io_ok && !tgt_mem_ok));

  assert_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !gated |-> (eff_io_en == cmd_io_en && eff_mem_en == cmd_mem_en && eff_mst_en == cmd_mst_en));

  assert_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_mode |-> !gated);

  assert_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gp_dir_out |-> !gated);

  assert_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drain_ok == cmd_mst_en);

  assert_cpl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gated |-> !cpl_ret_ok);

  assert_safe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    safe_pt |-> (gated && q_empty));

  assert_srst_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sec_rst_ctl |=> !sec_rst_n);

endmodule

// File: tb/sim_hotswap_txn_gate.sv
module sim_hotswap_txn_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_io_en = 1'b1, cmd_mem_en = 1'b0, cmd_mst_en = 1'b1;
  logic hs_mode = 1'b0, gp_dir_out = 1'b0, gp_pin = 1'b0;
  logic q_empty = 1'b0, sec_rst_ctl = 1'b0;
  logic eff_io_en, eff_mem_en, eff_mst_en, tgt_io_ok, tgt_mem_ok;
  logic drain_ok, cpl_ret_ok, gated, safe_pt, sec_rst_n;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hotswap_txn_gate u0 (.*);

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [7:0] outs();
    return {eff_io_en, eff_mem_en, eff_mst_en, tgt_io_ok, tgt_mem_ok, cpl_ret_ok, gated, safe_pt};
  endfunction

  task automatic t_reset();
    #1 chk("R1 sec_rst_n in reset", {7'd0, sec_rst_n}, 8'd0);
    cyc(2); rst_n = 1'b1; cyc(2);
    chk("R1 state after reset", outs(), 8'b10110100);
  endtask

  task automatic t_pass();
    cmd_io_en = 1'b0; cmd_mem_en = 1'b1; cmd_mst_en = 1'b0; #1;
    chk("R4 same-cycle mirror", {5'd0, eff_io_en, eff_mem_en, eff_mst_en}, 8'b010);
    cmd_io_en = 1'b1; cmd_mem_en = 1'b1; cmd_mst_en = 1'b1; #1;
    chk("R4 all set", {5'd0, eff_io_en, eff_mem_en, eff_mst_en}, 8'b111);
  endtask

  task automatic t_mode_off();
    hs_mode = 1'b0; gp_pin = 1'b1; cyc(3);
    chk("R2 mode off ignores pin", outs(), 8'b11111100);
    gp_pin = 1'b0; cyc(3);
  endtask

  task automatic t_dir_out();
    hs_mode = 1'b1; gp_dir_out = 1'b1; gp_pin = 1'b1; cyc(3);
    chk("R8 output pin disables gate", outs(), 8'b11111100);
    gp_pin = 1'b0; cyc(3); gp_dir_out = 1'b0;
  endtask

  task automatic t_gate_and_safe();
    hs_mode = 1'b1; gp_pin = 1'b1; q_empty = 1'b0;
    cyc(1);
    chk("R5 not gated after one edge", {7'd0, gated}, 8'd0);
    q_empty = 1'b1;
    cyc(1);
    chk("R3 R10 gated with empty queue", outs(), 8'b00000011);
    chk("R6 drain while gated", {7'd0, drain_ok}, 8'd1);
    q_empty = 1'b0; #1;
    chk("R10 safe needs empty", {7'd0, safe_pt}, 8'd0);
    chk("R7 completions held", {7'd0, cpl_ret_ok}, 8'd0);
    cmd_mst_en = 1'b0; #1;
    chk("R6 drain follows stored bit", {7'd0, drain_ok}, 8'd0);
    cmd_mst_en = 1'b1;
  endtask

  task automatic t_release();
    gp_pin = 1'b0; cyc(1);
    chk("R5 still gated after one edge", {7'd0, gated}, 8'd1);
    @(posedge clk); cmd_io_en = 1'b0; cmd_mem_en = 1'b1; cmd_mst_en = 1'b0;
    @(negedge clk);
    chk("R4 reopen with same-cycle write", outs(), 8'b01001100);
    hs_mode = 1'b0;
  endtask

  task automatic t_secrst();
    sec_rst_ctl = 1'b1; #1;
    chk("R9 not before edge", {7'd0, sec_rst_n}, 8'd1);
    cyc(1);
    chk("R9 asserted", {7'd0, sec_rst_n}, 8'd0);
    sec_rst_ctl = 1'b0; cyc(1);
    chk("R9 released", {7'd0, sec_rst_n}, 8'd1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_pass();
    t_mode_off();
    t_dir_out();
    t_gate_and_safe();
    t_release();
    t_secrst();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule